// File: doc/BRIEF.md
# I2C Status Flag Controller

This block keeps the event and status flags of a two-wire serial bus peripheral and decides when the serial clock has to be stretched. A separate bus engine does the shifting, clock generation and address comparison. That engine reports what happened on the bus through single-cycle strobes: start seen, stop seen, byte shifted, acknowledge clock done, address phase complete, own-address hit, general call, arbitration lost, bus error, and ten-bit header sent. The CPU side supplies access strobes for a status read, a data read and a data write. It also supplies a peripheral enable, a start request, an acknowledge enable and an interrupt enable.

The block turns these strobes into six flags: byte done, direction, busy, address hit, master, and ten-bit header. It drives an interrupt request from the flags. It holds the clock low while software still owes the block attention. The byte-done flag is released only by a status read followed by the data access that fits the direction of the last byte. An armed bit remembers that the status read has been seen. Driving the peripheral enable low clears all state.

Top module: `i2cflag_ctrl`

## Requirements
- R1: While `periph_en` is 0, all six flags, `irq` and `scl_hold` are 0 one cycle later, and strobes received during that time set nothing. This holds even when a set strobe arrives in the same cycle as the disable.
- R2: A byte marked as transmit (`byte_tx`=1, `byte_addr`=0 at `ev_byte_end`) sets `f_done` and `f_tx` in the cycle after its `ev_ack_done`.
- R3: A byte marked as receive (`byte_tx`=0, `byte_addr`=0) sets `f_done` with `f_tx`=0 after its `ev_ack_done`, but only when `ack_en`=1. With `ack_en`=0, `f_done` stays 0.
- R4: For an address byte (`byte_addr`=1), `ev_ack_done` does not set `f_done`. In master mode, `ev_addr_done` sets `f_done` with `f_tx`=1.
- R5: `f_done` clears only after a status read (`rd_status`) followed by the matching data access. The matching access is `wr_data` when `f_tx`=1 and `rd_data` when `f_tx`=0. A data access with no status read before it leaves `f_done` at 1.
- R6: Any bus strobe, or a non-matching data access, between the status read and the data access cancels the sequence. The later matching access then leaves `f_done` at 1.
- R7: `scl_hold` is 1 exactly while `f_done` or `f_addr_hit` is 1.
- R8: `f_addr_hit` sets on `ev_addr_match` or `ev_gen_call` and clears on `rd_status`.
- R9: `f_tx` clears when `f_done` clears, on `ev_stop`, and on `ev_arb_lost`.
- R10: `f_busy` sets on `ev_start` and clears on `ev_stop` or `ev_bus_err`.
- R11: `f_master` sets on `start_req` and clears on `ev_stop` or `ev_arb_lost`.
- R12: `f_hdr10` sets on `ev_hdr_sent` and clears on `wr_data`.
- R13: `irq` equals `irq_en` AND (`f_done` OR `f_addr_hit`).
- R14: When a set and a clear condition for the same flag arrive in one cycle, the flag ends at 1. The only exception is disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_en | input | 1 | Peripheral enable; 0 clears all state |
| irq_en | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| start_req | input | 1 | Software start request strobe |
| rd_status | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe |
| wr_data | input | 1 | Data register write strobe |
| ev_start | input | 1 | Start condition seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_byte_end | input | 1 | Eight bits shifted |
| byte_tx | input | 1 | Qualifies ev_byte_end: 1 transmit, 0 receive |
| byte_addr | input | 1 | Qualifies ev_byte_end: 1 address byte |
| ev_ack_done | input | 1 | Acknowledge clock pulse done |
| ev_addr_done | input | 1 | Master address phase complete |
| ev_addr_match | input | 1 | Own slave address matched |
| ev_gen_call | input | 1 | General call recognised |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Bus error |
| ev_hdr_sent | input | 1 | Ten-bit header byte sent |
| f_done | output | 1 | Byte transfer finished |
| f_tx | output | 1 | Last finished byte was transmitted |
| f_busy | output | 1 | Bus in use |
| f_addr_hit | output | 1 | Slave address matched |
| f_master | output | 1 | Master mode |
| f_hdr10 | output | 1 | Ten-bit header sent |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Hold serial clock low |

## Verification
The bench targets the read-then-access release of the byte-done flag. It checks a data access with no status read first, a data access in the wrong direction, and a bus strobe that falls between the read and the access. A design with a loose sequencer would release the held clock on any of these. The bench also checks an address byte whose acknowledge arrives before the address phase ends; a design that got this wrong would raise byte-done too early. It checks a received byte with acknowledge disabled, which must not set byte-done. Finally, it drives set and clear strobes in the same cycle, and a disable that arrives together with a start. Wrong priority there would leave a flag cleared when it should be set, or set when it should be cleared.

// File: rtl/i2cflag_pkg.sv
`timescale 1ns/1ps
package i2cflag_pkg;

   // bus engine strobes, one bit each
   typedef struct packed {
      logic start;
      logic stop;
      logic byte_end;
      logic ack_done;
      logic addr_done;
      logic addr_match;
      logic gen_call;
      logic arb_lost;
      logic bus_err;
      logic hdr_sent;
   } bus_ev_t;

   localparam int unsigned BUS_EV_W = $bits(bus_ev_t);

   // cpu access strobes
   typedef struct packed {
      logic rd_status;
      logic rd_data;
      logic wr_data;
   } cpu_acc_t;

   // flag slot positions inside the bank vector
   localparam int unsigned FL_DONE   = 0;
   localparam int unsigned FL_TX     = 1;
   localparam int unsigned FL_BUSY   = 2;
   localparam int unsigned FL_HIT    = 3;
   localparam int unsigned FL_MASTER = 4;
   localparam int unsigned FL_HDR10  = 5;
   localparam int unsigned FLAG_N    = 6;

   function automatic logic any_bus_ev(input bus_ev_t e);
      return |e;
   endfunction

endpackage

// File: rtl/i2cflag_cell.sv
`timescale 1ns/1ps
// one flag bit: kill beats set, set beats clear
module i2cflag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic kill,
   input  logic set,
   input  logic set_val,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (kill) begin
         q <= 1'b0;
      end else if (set) begin
         q <= set_val;
      end else if (clr) begin
         q <= 1'b0;
      end
   end
endmodule

// File: rtl/i2cflag_seq.sv
`timescale 1ns/1ps
// tracks the byte in flight and the status-read/data-access release sequence
module i2cflag_seq
   import i2cflag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  bus_ev_t  ev,
   input  logic     byte_tx,
   input  logic     byte_addr,
   input  logic     ack_en,
   input  logic     master_q,
   input  cpu_acc_t acc,
   input  logic     done_q,
   input  logic     tx_q,
   output logic     done_set,
   output logic     done_set_tx,
   output logic     done_clr
);
   logic pend_v, pend_tx, pend_addr;
   logic armed;
   logic ack_fires, addr_fires, match_acc, other_acc, intervene;

   // byte-in-flight record, captured at byte end, consumed by ack done
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_tx   <= 1'b0;
         pend_addr <= 1'b0;
      end else if (!en || ev.stop || ev.arb_lost) begin
         pend_v    <= 1'b0;
         pend_tx   <= 1'b0;
         pend_addr <= 1'b0;
      end else if (ev.byte_end) begin
         pend_v    <= 1'b1;
         pend_tx   <= byte_tx;
         pend_addr <= byte_addr;
      end else if (ev.ack_done) begin
         pend_v    <= 1'b0;
      end
   end

   always_comb begin
      ack_fires   = ev.ack_done && pend_v && !pend_addr && (pend_tx || ack_en);
      addr_fires  = ev.addr_done && master_q;
      done_set    = ack_fires || addr_fires;
      done_set_tx = addr_fires ? 1'b1 : pend_tx;
      match_acc   = tx_q ? acc.wr_data : acc.rd_data;
      other_acc   = tx_q ? acc.rd_data : acc.wr_data;
      intervene   = any_bus_ev(ev) || other_acc || match_acc;
      done_clr    = armed && match_acc && !any_bus_ev(ev);
   end

   // armed: a status read has been seen while byte done is pending
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (!en) begin
         armed <= 1'b0;
      end else if (acc.rd_status && done_q && !any_bus_ev(ev)) begin
         armed <= 1'b1;
      end else if (intervene) begin
         armed <= 1'b0;
      end
   end
endmodule

// File: rtl/i2cflag_bank.sv
`timescale 1ns/1ps
// computes set/clear terms per flag and holds them in generated cells
module i2cflag_bank
   import i2cflag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  bus_ev_t           ev,
   input  cpu_acc_t          acc,
   input  logic              start_req,
   input  logic              done_set,
   input  logic              done_set_tx,
   input  logic              done_clr,
   output logic [FLAG_N-1:0] flags
);
   logic [FLAG_N-1:0] set_v, val_v, clr_v;

   always_comb begin
      set_v = '0;
      val_v = '1;
      clr_v = '0;

      set_v[FL_DONE]   = done_set;
      clr_v[FL_DONE]   = done_clr;

      set_v[FL_TX]     = done_set;
      val_v[FL_TX]     = done_set_tx;
      clr_v[FL_TX]     = done_clr || ev.stop || ev.arb_lost;

      set_v[FL_BUSY]   = ev.start;
      clr_v[FL_BUSY]   = ev.stop || ev.bus_err;

      set_v[FL_HIT]    = ev.addr_match || ev.gen_call;
      clr_v[FL_HIT]    = acc.rd_status;

      set_v[FL_MASTER] = start_req;
      clr_v[FL_MASTER] = ev.stop || ev.arb_lost;

      set_v[FL_HDR10]  = ev.hdr_sent;
      clr_v[FL_HDR10]  = acc.wr_data;
   end

   for (genvar i = 0; i < FLAG_N; i++) begin : g_cell
      i2cflag_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .kill    (!en),
         .set     (set_v[i]),
         .set_val (val_v[i]),
         .clr     (clr_v[i]),
         .q       (flags[i])
      );
   end
endmodule

// File: rtl/i2cflag_ctrl.sv
`timescale 1ns/1ps
module i2cflag_ctrl
   import i2cflag_pkg::*;
#(
   parameter int unsigned IRQ_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic periph_en,
   input  logic irq_en,
   input  logic ack_en,
   input  logic start_req,
   input  logic rd_status,
   input  logic rd_data,
   input  logic wr_data,
   input  logic ev_start,
   input  logic ev_stop,
   input  logic ev_byte_end,
   input  logic byte_tx,
   input  logic byte_addr,
   input  logic ev_ack_done,
   input  logic ev_addr_done,
   input  logic ev_addr_match,
   input  logic ev_gen_call,
   input  logic ev_arb_lost,
   input  logic ev_bus_err,
   input  logic ev_hdr_sent,
   output logic f_done,
   output logic f_tx,
   output logic f_busy,
   output logic f_addr_hit,
   output logic f_master,
   output logic f_hdr10,
   output logic irq,
   output logic scl_hold
);
   if (IRQ_STAGES > 1) begin : g_bad_irq_stages
      $error("IRQ_STAGES must be 0 or 1");
   end
   if (BUS_EV_W != 10) begin : g_bad_ev_width
      $error("bus event bundle width mismatch");
   end

   bus_ev_t           ev;
   cpu_acc_t          acc;
   logic [FLAG_N-1:0] flags;
   logic              done_set, done_set_tx, done_clr;
   logic              want_irq;

   assign ev = '{start:ev_start, stop:ev_stop, byte_end:ev_byte_end,
                 ack_done:ev_ack_done, addr_done:ev_addr_done,
                 addr_match:ev_addr_match, gen_call:ev_gen_call,
                 arb_lost:ev_arb_lost, bus_err:ev_bus_err,
                 hdr_sent:ev_hdr_sent};
   assign acc = '{rd_status:rd_status, rd_data:rd_data, wr_data:wr_data};

   i2cflag_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (periph_en),
      .ev          (ev),
      .byte_tx     (byte_tx),
      .byte_addr   (byte_addr),
      .ack_en      (ack_en),
      .master_q    (flags[FL_MASTER]),
      .acc         (acc),
      .done_q      (flags[FL_DONE]),
      .tx_q        (flags[FL_TX]),
      .done_set    (done_set),
      .done_set_tx (done_set_tx),
      .done_clr    (done_clr)
   );

   i2cflag_bank u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (periph_en),
      .ev          (ev),
      .acc         (acc),
      .start_req   (start_req),
      .done_set    (done_set),
      .done_set_tx (done_set_tx),
      .done_clr    (done_clr),
      .flags       (flags)
   );

   assign f_done     = flags[FL_DONE];
   assign f_tx       = flags[FL_TX];
   assign f_busy     = flags[FL_BUSY];
   assign f_addr_hit = flags[FL_HIT];
   assign f_master   = flags[FL_MASTER];
   assign f_hdr10    = flags[FL_HDR10];

   assign scl_hold = flags[FL_DONE] | flags[FL_HIT];
   assign want_irq = irq_en & scl_hold;

   if (IRQ_STAGES == 0) begin : g_irq_comb
      assign irq = want_irq;
   end else begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= want_irq && periph_en;
      end
      assign irq = irq_q;
   end
endmodule

// File: rtl/i2cflag_chk.sv
`timescale 1ns/1ps
module i2cflag_chk (
   input logic clk,
   input logic rst_n,
   input logic periph_en,
   input logic start_req,
   input logic rd_data,
   input logic wr_data,
   input logic ev_start,
   input logic ev_addr_match,
   input logic ev_hdr_sent,
   input logic f_done,
   input logic f_tx,
   input logic f_busy,
   input logic f_addr_hit,
   input logic f_master,
   input logic f_hdr10
);
   // R1
   disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !periph_en |=> !(f_done || f_tx || f_busy || f_addr_hit || f_master || f_hdr10));

   // R5
   done_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f_done && periph_en && !rd_data && !wr_data) |=> (f_done || !periph_en));

   // R8
   addr_hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_addr_match && periph_en) |=> (f_addr_hit || !periph_en));

   // R10
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start && periph_en) |=> (f_busy || !periph_en));

   // R11
   master_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && periph_en) |=> (f_master || !periph_en));

   // R12
   hdr10_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_hdr_sent && periph_en) |=> (f_hdr10 || !periph_en));
endmodule

bind i2cflag_ctrl i2cflag_chk u_chk (.*);

// File: tb/i2cflag_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2cflag_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic periph_en = 1'b0, irq_en = 1'b0, ack_en = 1'b0;
   logic start_req = 1'b0, rd_status = 1'b0, rd_data = 1'b0, wr_data = 1'b0;
   logic byte_tx = 1'b0, byte_addr = 1'b0;
   logic [9:0] evv = '0;
   logic f_done, f_tx, f_busy, f_addr_hit, f_master, f_hdr10, irq, scl_hold;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   // bench-side strobe masks
   localparam logic [9:0] E_START = 10'd1,   E_STOP  = 10'd2,   E_BEND = 10'd4;
   localparam logic [9:0] E_ACK   = 10'd8,   E_ADONE = 10'd16,  E_MATCH = 10'd32;
   localparam logic [9:0] E_GCALL = 10'd64,  E_ARB   = 10'd128, E_BERR  = 10'd256;
   localparam logic [9:0] E_HDR   = 10'd512;

   always #2.5 clk = ~clk;

   i2cflag_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .irq_en(irq_en),
      .ack_en(ack_en), .start_req(start_req), .rd_status(rd_status),
      .rd_data(rd_data), .wr_data(wr_data),
      .ev_start(evv[0]), .ev_stop(evv[1]), .ev_byte_end(evv[2]),
      .byte_tx(byte_tx), .byte_addr(byte_addr),
      .ev_ack_done(evv[3]), .ev_addr_done(evv[4]), .ev_addr_match(evv[5]),
      .ev_gen_call(evv[6]), .ev_arb_lost(evv[7]), .ev_bus_err(evv[8]),
      .ev_hdr_sent(evv[9]),
      .f_done(f_done), .f_tx(f_tx), .f_busy(f_busy), .f_addr_hit(f_addr_hit),
      .f_master(f_master), .f_hdr10(f_hdr10), .irq(irq), .scl_hold(scl_hold)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // one-cycle strobe; returns at the negedge after the capturing posedge
   task automatic step(input logic [9:0] m, input logic rs, input logic rd,
                       input logic wr, input logic sr);
      @(negedge clk);
      evv = m; rd_status = rs; rd_data = rd; wr_data = wr; start_req = sr;
      @(negedge clk);
      evv = '0; rd_status = 0; rd_data = 0; wr_data = 0; start_req = 0;
   endtask

   task automatic ev(input logic [9:0] m);
      step(m, 0, 0, 0, 0);
   endtask

   task automatic send_byte(input logic tx, input logic adr);
      byte_tx = tx; byte_addr = adr;
      ev(E_BEND);
      ev(E_ACK);
   endtask

   task automatic clean();
      @(negedge clk); periph_en = 0;
      @(negedge clk); periph_en = 1;
   endtask

   task automatic t_reset();
      chk("R1", "done after reset", f_done, 0);
      chk("R1", "busy after reset", f_busy, 0);
      chk("R1", "hold after reset", scl_hold, 0);
      chk("R1", "irq after reset", irq, 0);
   endtask

   task automatic t_tx();
      irq_en = 1;
      send_byte(1, 0);
      chk("R2", "tx byte done", f_done, 1);
      chk("R2", "tx dir", f_tx, 1);
      chk("R7", "hold on done", scl_hold, 1);
      chk("R13", "irq on done", irq, 1);
      step('0, 0, 0, 1, 0);
      chk("R5", "write without status read", f_done, 1);
      step('0, 1, 0, 0, 0);
      step('0, 0, 0, 1, 0);
      chk("R5", "read then write clears", f_done, 0);
      chk("R9", "tx clears with done", f_tx, 0);
      chk("R7", "hold released", scl_hold, 0);
      chk("R13", "irq released", irq, 0);
      irq_en = 0;
   endtask

   task automatic t_rx();
      ack_en = 1;
      send_byte(0, 0);
      chk("R3", "rx byte done", f_done, 1);
      chk("R3", "rx dir", f_tx, 0);
      step('0, 1, 0, 0, 0);
      step('0, 0, 0, 1, 0);
      chk("R6", "wrong-direction access keeps done", f_done, 1);
      step('0, 1, 0, 0, 0);
      step('0, 0, 1, 0, 0);
      chk("R5", "read then read clears", f_done, 0);
      ack_en = 0;
      send_byte(0, 0);
      chk("R3", "rx without ack enable", f_done, 0);
   endtask

   task automatic t_armed();
      send_byte(1, 0);
      step('0, 1, 0, 0, 0);
      ev(E_START);
      step('0, 0, 0, 1, 0);
      chk("R6", "intervening strobe cancels", f_done, 1);
      step('0, 1, 0, 0, 0);
      step('0, 0, 0, 1, 0);
      chk("R6", "fresh sequence clears", f_done, 0);
      clean();
   endtask

   task automatic t_addr();
      step('0, 0, 0, 0, 1);
      chk("R11", "start request sets master", f_master, 1);
      send_byte(1, 1);
      chk("R4", "ack of address byte no done", f_done, 0);
      ev(E_ADONE);
      chk("R4", "address phase sets done", f_done, 1);
      chk("R4", "address phase tx", f_tx, 1);
      ev(E_ARB);
      chk("R11", "arb lost clears master", f_master, 0);
      chk("R9", "arb lost clears tx", f_tx, 0);
      step('0, 0, 0, 0, 1);
      ev(E_STOP);
      chk("R11", "stop clears master", f_master, 0);
      clean();
   endtask

   task automatic t_hit();
      irq_en = 0;
      ev(E_MATCH);
      chk("R8", "match sets hit", f_addr_hit, 1);
      chk("R7", "hold on hit", scl_hold, 1);
      chk("R13", "irq masked", irq, 0);
      step('0, 1, 0, 0, 0);
      chk("R8", "status read clears hit", f_addr_hit, 0);
      ev(E_GCALL);
      chk("R8", "general call sets hit", f_addr_hit, 1);
      irq_en = 1; #0.1;
      chk("R13", "irq on hit", irq, 1);
      irq_en = 0;
      step('0, 1, 0, 0, 0);
      chk("R7", "hold released after hit", scl_hold, 0);
   endtask

   task automatic t_busy();
      ev(E_START);
      chk("R10", "start sets busy", f_busy, 1);
      ev(E_STOP);
      chk("R10", "stop clears busy", f_busy, 0);
      ev(E_START);
      ev(E_BERR);
      chk("R10", "bus error clears busy", f_busy, 0);
      send_byte(1, 0);
      ev(E_STOP);
      chk("R9", "stop clears tx", f_tx, 0);
      clean();
   endtask

   task automatic t_hdr();
      ev(E_HDR);
      chk("R12", "header sets flag", f_hdr10, 1);
      step('0, 0, 0, 1, 0);
      chk("R12", "data write clears header", f_hdr10, 0);
   endtask

   task automatic t_collide();
      step(E_START | E_STOP, 0, 0, 0, 0);
      chk("R14", "start and stop together", f_busy, 1);
      step(E_MATCH, 1, 0, 0, 0);
      chk("R14", "match and status read together", f_addr_hit, 1);
      step(E_HDR, 0, 0, 1, 0);
      chk("R14", "header and write together", f_hdr10, 1);
      @(negedge clk);
      periph_en = 0; evv = E_START;
      @(negedge clk);
      evv = '0;
      chk("R14", "disable beats start", f_busy, 0);
      periph_en = 1;
   endtask

   task automatic t_disable();
      ev(E_START | E_MATCH | E_HDR);
      step('0, 0, 0, 0, 1);
      @(negedge clk); periph_en = 0;
      @(negedge clk);
      chk("R1", "disable clears busy", f_busy, 0);
      chk("R1", "disable clears hit", f_addr_hit, 0);
      chk("R1", "disable clears master", f_master, 0);
      chk("R1", "disable clears header", f_hdr10, 0);
      ev(E_START);
      chk("R1", "start ignored when disabled", f_busy, 0);
      periph_en = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      periph_en = 1;
      t_tx();
      t_rx();
      t_armed();
      t_addr();
      t_hit();
      t_busy();
      t_hdr();
      t_collide();
      t_disable();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule